// File: doc/BRIEF.md
# Post-Add Renormalizer

This block sits after the significand adder of a floating-point add/subtract pipeline. It takes the raw sum and the exponent of the larger operand, and it returns a significand whose leading one is back at the integer position, with a matching exponent. If the sum overflowed into the second integer bit, the block moves it right by one place. If cancellation left leading zeros, it moves it left. If moving it fully left would push the exponent below the smallest normal value, it stops early and produces a correctly encoded subnormal. A zero sum gives a clean zero. Operands that carry the all-ones exponent (infinity or NaN) pass through untouched.

Rounding happens downstream, so every guard bit is kept. When the significand moves right, the bit that falls off is folded into the lowest guard bit so that it is not lost. The result is registered once, and a valid strobe travels alongside it.

Top module: `renorm_top`

## Requirements
- R1: While reset is asserted, and at the first sample after reset, outValid, mantOut, expOut, zeroOut and denormOut are all zero.
- R2: A result appears exactly one clock after inValid is high. When inValid is low, outValid is low on the next clock and every result output holds its previous value.
- R3: sumIn is read as bit SUM_W-1 = second integer (carry) bit, bit SUM_W-2 = integer bit, then FRAC_W fraction bits, then GUARD_W guard bits, with the lowest bit acting as sticky. When the carry bit is set, mantOut = sumIn[SUM_W-1:1] with its bit 0 replaced by sumIn[1] OR sumIn[0], and expOut = exponent + 1.
- R4: When the carry bit is clear and the integer bit is set, mantOut = sumIn[SUM_W-2:0] and expOut equals the exponent unchanged.
- R5: When the leading one sits k places below the integer bit and k is smaller than the exponent, mantOut is sumIn[SUM_W-2:0] shifted left by k, and expOut = exponent - k. In that case mantOut's top bit is set.
- R6: When k is not smaller than the exponent, mantOut is sumIn[SUM_W-2:0] shifted left by exponent - 1, expOut = 0 and denormOut = 1.
- R7: An all-zero sumIn gives mantOut = 0, expOut = 0, zeroOut = 1 and denormOut = 0.
- R8: An all-ones expIn bypasses normalization: mantOut = sumIn[SUM_W-2:0], expOut = expIn, and both flags are 0.
- R9: An expIn of 0 (a subnormal operand) is handled with an effective exponent of 1 in R3 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | sumIn and expIn carry a new operation |
| sumIn | input | FRAC_W+GUARD_W+2 | Adder output, two integer bits, fraction, guard bits |
| expIn | input | EXP_W | Biased exponent of the larger operand |
| outValid | output | 1 | Result registers were loaded on the last clock |
| mantOut | output | FRAC_W+GUARD_W+1 | Integer bit, fraction and guard bits of the result |
| expOut | output | EXP_W | Adjusted biased exponent field |
| zeroOut | output | 1 | Sum cancelled to exactly zero |
| denormOut | output | 1 | Result is subnormal (exponent field 0, integer bit 0) |

## Verification
The bench sweeps every sum against every exponent in a narrow configuration.

- **Left-shift limit.** The sweep covers the boundary where the leading-zero count equals the exponent, and the one just below it. A limit that is off by one either leaves a normal result with exponent 0, or gives a subnormal whose integer bit is set.
- **Carry path.** Sums with the carry bit and a nonzero bottom bit show whether the shifted-out bit is folded into the sticky position. Dropping it would make a later round-to-nearest tie decision wrong.
- **Exponent 0 input.** Cases with an input exponent of 0 show whether it is treated as 1. A design that treats it as 0 shifts subnormals one place too far.
- **Bypass exponent.** The all-ones exponent shows whether normalization is skipped. A design that does not skip it corrupts NaN payloads.

// File: rtl/renorm_pkg.sv
package renorm_pkg;
  // Strobes from the control path that steer the significand datapath.
  typedef struct packed {
    logic bypass;     // special operand, pass significand through
    logic forceZero;  // cancelled sum, hardwired zero
    logic rightOne;   // final one-place right shift with sticky fold
    logic denorm;     // left shift was capped by the exponent
  } renormStrobes_t;
endpackage

// File: rtl/renorm_lzd.sv
module renorm_lzd #(
  parameter int FIELD_W = 57,
  parameter int CNT_W   = 6
) (
  input  logic [FIELD_W-1:0] field,
  output logic [CNT_W-1:0]   lzCount
);
  // Count of zeros above the highest set bit; FIELD_W when field is empty.
  always_comb begin
    lzCount = CNT_W'(FIELD_W);
    for (int i = 0; i < FIELD_W; i++) begin
      if (field[i]) lzCount = CNT_W'(FIELD_W - 1 - i);
    end
  end
endmodule

// File: rtl/renorm_ctrl.sv
module renorm_ctrl
  import renorm_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int SUM_W = 58,
  parameter int LZ_W  = 6
) (
  input  logic [SUM_W-1:0]  sumIn,
  input  logic [EXP_W-1:0]  expIn,
  output renormStrobes_t    strb,
  output logic [LZ_W-1:0]   shiftAmt,
  output logic [EXP_W-1:0]  expNext
);
  localparam int CMP_W = ((EXP_W > LZ_W) ? EXP_W : LZ_W) + 1;

  logic [LZ_W-1:0]  lzCount;
  logic [EXP_W-1:0] effExp;
  logic [CMP_W-1:0] lzExt;
  logic [CMP_W-1:0] effExt;

  renorm_lzd #(.FIELD_W(SUM_W-1), .CNT_W(LZ_W)) i_lzd (
    .field  (sumIn[SUM_W-2:0]),
    .lzCount(lzCount)
  );

  // A zero exponent field (subnormal operand) scales like exponent 1.
  assign effExp = (expIn == '0) ? EXP_W'(1) : expIn;
  assign lzExt  = CMP_W'(lzCount);
  assign effExt = CMP_W'(effExp);

  always_comb begin
    strb     = '0;
    shiftAmt = '0;
    expNext  = effExp;
    if (&expIn) begin
      strb.bypass = 1'b1;
      expNext     = expIn;
    end else if (sumIn == '0) begin
      strb.forceZero = 1'b1;
      expNext        = '0;
    end else if (sumIn[SUM_W-1]) begin
      strb.rightOne = 1'b1;
      expNext       = effExp + EXP_W'(1);
    end else if (lzExt < effExt) begin
      shiftAmt = lzCount;
      expNext  = EXP_W'(effExt - lzExt);
    end else begin
      // Shift as far as the exponent allows, then back one place.
      shiftAmt      = effExt[LZ_W-1:0];
      strb.rightOne = 1'b1;
      strb.denorm   = 1'b1;
      expNext       = '0;
    end
  end
endmodule

// File: rtl/renorm_dp.sv
module renorm_dp
  import renorm_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int SUM_W = 58,
  parameter int LZ_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [SUM_W-1:0]  sumIn,
  input  renormStrobes_t    strb,
  input  logic [LZ_W-1:0]   shiftAmt,
  input  logic [EXP_W-1:0]  expNext,
  output logic              outValid,
  output logic [SUM_W-2:0]  mantOut,
  output logic [EXP_W-1:0]  expOut,
  output logic              zeroOut,
  output logic              denormOut
);
  logic [SUM_W-1:0] shifted;
  logic [SUM_W-2:0] mantNext;

  assign shifted = sumIn << shiftAmt;

  always_comb begin
    if (strb.forceZero)     mantNext = '0;
    else if (strb.bypass)   mantNext = sumIn[SUM_W-2:0];
    else if (strb.rightOne) mantNext = {shifted[SUM_W-1:2], shifted[1] | shifted[0]};
    else                    mantNext = shifted[SUM_W-2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      mantOut   <= '0;
      expOut    <= '0;
      zeroOut   <= 1'b0;
      denormOut <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        mantOut   <= mantNext;
        expOut    <= expNext;
        zeroOut   <= strb.forceZero;
        denormOut <= strb.denorm;
      end
    end
  end
endmodule

// File: rtl/renorm_top.sv
module renorm_top
  import renorm_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter int GUARD_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [FRAC_W+GUARD_W+1:0] sumIn,
  input  logic [EXP_W-1:0]          expIn,
  output logic                      outValid,
  output logic [FRAC_W+GUARD_W:0]   mantOut,
  output logic [EXP_W-1:0]          expOut,
  output logic                      zeroOut,
  output logic                      denormOut
);
  localparam int SUM_W = FRAC_W + GUARD_W + 2;
  localparam int LZ_W  = $clog2(SUM_W);

  renormStrobes_t   strb;
  logic [LZ_W-1:0]  shiftAmt;
  logic [EXP_W-1:0] expNext;

  renorm_ctrl #(.EXP_W(EXP_W), .SUM_W(SUM_W), .LZ_W(LZ_W)) i_ctrl (
    .sumIn   (sumIn),
    .expIn   (expIn),
    .strb    (strb),
    .shiftAmt(shiftAmt),
    .expNext (expNext)
  );

  renorm_dp #(.EXP_W(EXP_W), .SUM_W(SUM_W), .LZ_W(LZ_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .sumIn    (sumIn),
    .strb     (strb),
    .shiftAmt (shiftAmt),
    .expNext  (expNext),
    .outValid (outValid),
    .mantOut  (mantOut),
    .expOut   (expOut),
    .zeroOut  (zeroOut),
    .denormOut(denormOut)
  );
endmodule

// File: rtl/renorm_chk.sv
module renorm_chk #(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter int GUARD_W = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      inValid,
  input logic [FRAC_W+GUARD_W+1:0] sumIn,
  input logic [EXP_W-1:0]          expIn,
  input logic                      outValid,
  input logic [FRAC_W+GUARD_W:0]   mantOut,
  input logic [EXP_W-1:0]          expOut,
  input logic                      zeroOut,
  input logic                      denormOut
);
  localparam int SUM_W  = FRAC_W + GUARD_W + 2;
  localparam int MANT_W = SUM_W - 1;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(mantOut) && $stable(expOut)));

  // R7
  zero_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && zeroOut) |-> (mantOut == '0 && expOut == '0 && !denormOut));

  // R6
  denorm_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && denormOut) |-> (expOut == '0 && !mantOut[MANT_W-1] && mantOut != '0));

  // R5
  normal_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !zeroOut && !denormOut && !(&expOut)) |-> mantOut[MANT_W-1]);

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (&expIn)) |=> (expOut == $past(expIn)
                               && mantOut == $past(sumIn[SUM_W-2:0])
                               && !zeroOut && !denormOut));

  // R3
  carry_exp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sumIn[SUM_W-1] && !(&expIn) && expIn != '0)
      |=> (expOut == $past(expIn) + EXP_W'(1)));
endmodule

bind renorm_top renorm_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W)) i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .sumIn(sumIn), .expIn(expIn),
  .outValid(outValid), .mantOut(mantOut), .expOut(expOut),
  .zeroOut(zeroOut), .denormOut(denormOut)
);

// File: tb/test_renorm_top.sv
`timescale 1ns/1ps
module test_renorm_top;
  localparam int EW = 4;
  localparam int FW = 3;
  localparam int GW = 3;
  localparam int SW = FW + GW + 2;
  localparam int MW = SW - 1;
  localparam int HI = SW - 2;
  localparam int EMAX = (1 << EW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [SW-1:0] sumIn = '0;
  logic [EW-1:0] expIn = '0;
  logic          outValid;
  logic [MW-1:0] mantOut;
  logic [EW-1:0] expOut;
  logic          zeroOut;
  logic          denormOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  renorm_top #(.EXP_W(EW), .FRAC_W(FW), .GUARD_W(GW)) i_renorm_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sumIn(sumIn), .expIn(expIn),
    .outValid(outValid), .mantOut(mantOut), .expOut(expOut),
    .zeroOut(zeroOut), .denormOut(denormOut)
  );

  task automatic check(input string tag, input int aM, input int aE, input int aZ,
                       input int aD, input int aV, input int eM, input int eE,
                       input int eZ, input int eD, input int eV, input int s, input int x);
    checks++;
    if (aM != eM || aE != eE || aZ != eZ || aD != eD || aV != eV) begin
      errors++;
      $display("FAIL %s sum=%0d exp=%0d: got mant=%0d exp=%0d z=%0d d=%0d v=%0d expected mant=%0d exp=%0d z=%0d d=%0d v=%0d",
               tag, s, x, aM, aE, aZ, aD, aV, eM, eE, eZ, eD, eV);
    end
  endtask

  // Arithmetic reference model built from the requirements.
  task automatic model(input int s, input int x, output int m, output int e,
                       output int z, output int d, output string tag);
    int p, ee, tgt;
    m = 0; e = 0; z = 0; d = 0;
    if (x == EMAX) begin
      m = s & ((1 << MW) - 1); e = x; tag = "R8";
    end else if (s == 0) begin
      z = 1; tag = "R7";
    end else begin
      ee = (x == 0) ? 1 : x;
      p = 0;
      for (int i = 0; i < SW; i++) if (((s >> i) & 1) != 0) p = i;
      tgt = ee + p - HI;
      if (p == HI + 1) begin
        m = (s >> 1) | (s & 1); e = tgt; tag = "R3";
      end else if (tgt >= 1) begin
        m = (s << (HI - p)) & ((1 << MW) - 1); e = tgt;
        tag = (p == HI) ? "R4" : "R5";
      end else begin
        m = (s << (ee - 1)) & ((1 << MW) - 1); e = 0; d = 1; tag = "R6";
      end
      if (x == 0) tag = {tag, "/R9"};
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int m, e, z, d;
    string tag;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check("R1", int'(mantOut), int'(expOut), int'(zeroOut), int'(denormOut), int'(outValid),
          0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    // R1 after release with no operation
    check("R1", int'(mantOut), int'(expOut), int'(zeroOut), int'(denormOut), int'(outValid),
          0, 0, 0, 0, 0, 0, 0);

    // Exhaustive sweep: every sum against every exponent (R3..R9).
    for (int x = 0; x <= EMAX; x++) begin
      for (int s = 0; s < (1 << SW); s++) begin
        @(negedge clk);
        inValid = 1'b1;
        sumIn   = SW'(s);
        expIn   = EW'(x);
        @(posedge clk);
        #1;
        model(s, x, m, e, z, d, tag);
        check(tag, int'(mantOut), int'(expOut), int'(zeroOut), int'(denormOut),
              int'(outValid), m, e, z, d, 1, s, x);
      end
    end

    // R2: idle cycles leave the last result in place.
    @(negedge clk);
    inValid = 1'b1;
    sumIn   = SW'(8'h2D);
    expIn   = EW'(5);
    @(posedge clk);
    #1;
    model(8'h2D, 5, m, e, z, d, tag);
    check(tag, int'(mantOut), int'(expOut), int'(zeroOut), int'(denormOut),
          int'(outValid), m, e, z, d, 1, 8'h2D, 5);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      sumIn   = SW'(k * 37 + 1);
      expIn   = EW'(k);
      @(posedge clk);
      #1;
      check("R2", int'(mantOut), int'(expOut), int'(zeroOut), int'(denormOut),
            int'(outValid), m, e, z, d, 0, k * 37 + 1, k);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule